// File: doc/BRIEF.md
# Low-Power Stop Recovery Sequencer

This block decides when a processor core may leave its Stop low-power state and fetch its first instruction again. A stop request moves it from normal running into Stop. In Stop it powers down the oscillator and the PLL, unless the PLL is configured to keep running through Stop. A wake interrupt starts recovery. During recovery two waits run side by side: a stabilization delay counter and a wait for PLL lock. The core is released only when the slower of the two has finished.

Three configuration bits choose which waits apply. They are captured on the cycle the stop request is accepted and stay fixed until release, so changes made while the core sleeps have no effect.

At release the block gives a one-cycle strobe. With it comes a flag telling whether the wake request was still asserted at that moment, so that a level-sensitive wake interrupt is either serviced or skipped.

Top module: `stop_recovery_seq`

## Requirements
- R1: After a synchronous reset the block is in the running state. `osc_pd`, `pll_pd`, `core_release` and `wake_serviced` are all 0, and the delay counter is cleared.
- R2: A `stop_req` sampled high while running moves the block into Stop on the next clock edge. `cfg_pll_en`, `cfg_pll_in_stop` and `cfg_no_delay` are captured on that same edge. While in Stop, `osc_pd` and `pll_pd` are 1 when the captured PLL-in-Stop bit is 0, and both are 0 when it is 1.
- R3: When the captured PLL-in-Stop bit is 1, recovery applies neither the delay nor the lock wait, whatever the other two bits hold. The release strobe rises one cycle after the edge that samples the wake input.
- R4: When the captured PLL-in-Stop bit is 0 and the captured delay-disable bit is 0, recovery lasts at least DELAY_CYCLES clock cycles. With no lock wait outstanding, the strobe rises DELAY_CYCLES edges after the edge that samples the wake input.
- R5: When the captured PLL-in-Stop bit is 0 and the captured delay-disable bit is 1, no stabilization count is applied.
- R6: When the captured PLL-enable bit is 1 and the captured PLL-in-Stop bit is 0, release also waits for `pll_locked`. A lock indication seen in any recovery cycle counts as done, even if it drops again later. Release follows in the first recovery cycle in which both waits have finished.
- R7: When the captured PLL-enable bit is 0, the lock wait counts as already complete and `pll_locked` has no effect.
- R8: `core_release` is a single-cycle pulse. It appears only directly after a recovery cycle, and the block is running again on the next cycle.
- R9: `wake_serviced` is 1 during the release pulse exactly when `wake_irq` was high in the last recovery cycle. At all other times it is 0.
- R10: `wake_irq` has no effect while running. `stop_req` has no effect in Stop or during recovery. Configuration changes after stop entry have no effect until the next stop entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req | input | 1 | Request to enter Stop (accepted while running) |
| wake_irq | input | 1 | Wake interrupt request, level |
| cfg_pll_en | input | 1 | PLL in use |
| cfg_pll_in_stop | input | 1 | PLL and oscillator kept running during Stop |
| cfg_no_delay | input | 1 | Skip the stabilization count |
| pll_locked | input | 1 | Lock indication from the PLL |
| osc_pd | output | 1 | Oscillator power-down control |
| pll_pd | output | 1 | PLL power-down control |
| core_release | output | 1 | One-cycle strobe permitting the first instruction fetch |
| wake_serviced | output | 1 | Wake request still asserted at release |

## Verification
The power-down outputs follow one cycle after the edge that accepts `stop_req`. The release strobe is due max(D, L+1) edges after the edge that samples `wake_irq`. Here D is DELAY_CYCLES when the count applies and 1 when it does not, and L is the index, counted from 0, of the first recovery cycle in which lock is seen (0 when no lock wait applies). The bench drives its inputs at falling edges and counts falling edges from the wake sample, so a release seen at count max(D, L+1)+1 is exactly on time. On every cycle a behavioural reference model predicts all four outputs, and the outputs are compared with it at the falling edge.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_WAKE = 2'd2,
        ST_GO   = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       keep_pll;
        logic       skip_dly;
        logic       pll_on;
        logic       wake_lvl;
    } seq_regs_t;

endpackage

// File: rtl/stab_delay_ctr.sv
module stab_delay_ctr #(
    parameter int unsigned DELAY_CYCLES = 131072
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic count_done
);
    localparam int unsigned CW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count_done = (cnt_q == LAST);

    // R4: counter saturates at the terminal value
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R4: every recovery starts counting from zero
    a_r4_cnt_cleared: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/pll_lock_gate.sv
module pll_lock_gate (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic need_lock,
    input  logic pll_locked,
    output logic lock_done
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        if (clear)           seen_d = 1'b0;
        else if (pll_locked) seen_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= seen_d;
    end

    assign lock_done = !need_lock || seen_q || pll_locked;

    // R6: a lock seen during recovery is remembered
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !clear) |=> seen_q);

endmodule

// File: rtl/stop_recovery_seq.sv
module stop_recovery_seq
    import stop_seq_pkg::*;
#(
    parameter int unsigned DELAY_CYCLES = 131072
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic wake_irq,
    input  logic cfg_pll_en,
    input  logic cfg_pll_in_stop,
    input  logic cfg_no_delay,
    input  logic pll_locked,
    output logic osc_pd,
    output logic pll_pd,
    output logic core_release,
    output logic wake_serviced
);
    seq_regs_t r_d, r_q;

    logic in_recover;
    logic need_dly;
    logic need_lock;
    logic cnt_done;
    logic dly_ok;
    logic lock_done;

    assign in_recover = (r_q.state == ST_WAKE);
    assign need_dly   = !r_q.keep_pll && !r_q.skip_dly;
    assign need_lock  = r_q.pll_on && !r_q.keep_pll;
    assign dly_ok     = !need_dly || cnt_done;

    stab_delay_ctr #(.DELAY_CYCLES(DELAY_CYCLES)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .clear      (!in_recover),
        .count_done (cnt_done)
    );

    pll_lock_gate u_lock (
        .clk        (clk),
        .rst        (rst),
        .clear      (!in_recover),
        .need_lock  (need_lock),
        .pll_locked (pll_locked),
        .lock_done  (lock_done)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_RUN: begin
                if (stop_req) begin
                    r_d.state    = ST_HALT;
                    r_d.keep_pll = cfg_pll_in_stop;
                    r_d.skip_dly = cfg_no_delay;
                    r_d.pll_on   = cfg_pll_en;
                end
            end
            ST_HALT: begin
                if (wake_irq) r_d.state = ST_WAKE;
            end
            ST_WAKE: begin
                if (dly_ok && lock_done) begin
                    r_d.state    = ST_GO;
                    r_d.wake_lvl = wake_irq;
                end
            end
            ST_GO: begin
                r_d.state    = ST_RUN;
                r_d.wake_lvl = 1'b0;
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_RUN, keep_pll: 1'b0, skip_dly: 1'b0,
                     pll_on: 1'b0, wake_lvl: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign osc_pd        = (r_q.state == ST_HALT) && !r_q.keep_pll;
    assign pll_pd        = (r_q.state == ST_HALT) && !r_q.keep_pll;
    assign core_release  = (r_q.state == ST_GO);
    assign wake_serviced = (r_q.state == ST_GO) && r_q.wake_lvl;

    // R8: strobe lasts exactly one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        core_release |=> !core_release);

    // R8: strobe only directly after recovery
    a_r8_after_recover: assert property (@(posedge clk) disable iff (rst)
        $rose(core_release) |-> ($past(r_q.state) == ST_WAKE));

    // R10: wake input cannot leave the running state
    a_r10_run_holds: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_RUN && !stop_req) |=> (r_q.state == ST_RUN));

    // R4: release with the count applied needs a finished counter
    a_r4_delay_met: assert property (@(posedge clk) disable iff (rst)
        ($rose(core_release) && !r_q.keep_pll && !r_q.skip_dly) |-> $past(cnt_done));

    // R2: captured configuration stays fixed while asleep
    a_r2_cfg_held: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_HALT || r_q.state == ST_WAKE) |=>
            ($stable(r_q.keep_pll) && $stable(r_q.skip_dly) && $stable(r_q.pll_on)));

endmodule

// File: tb/test_stop_recovery_seq.sv
module test_stop_recovery_seq;
    localparam int N = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req = 0, wake_irq = 0, cfg_pll_en = 0, cfg_pll_in_stop = 0;
    logic cfg_no_delay = 0, pll_locked = 0;
    logic osc_pd, pll_pd, core_release, wake_serviced;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    stop_recovery_seq #(.DELAY_CYCLES(N)) i_stop_recovery_seq (
        .clk(clk), .rst(rst), .stop_req(stop_req), .wake_irq(wake_irq),
        .cfg_pll_en(cfg_pll_en), .cfg_pll_in_stop(cfg_pll_in_stop),
        .cfg_no_delay(cfg_no_delay), .pll_locked(pll_locked),
        .osc_pd(osc_pd), .pll_pd(pll_pd), .core_release(core_release),
        .wake_serviced(wake_serviced));

    // behavioural reference model
    int m_st = 0;
    int m_rec = 0;
    bit m_keep = 0, m_skip = 0, m_pllen = 0, m_seen = 0, m_wake = 0;

    always @(posedge clk) begin
        bit lock_now, ok_d, ok_l;
        if (rst) begin
            m_st = 0; m_rec = 0; m_seen = 0; m_wake = 0;
        end else begin
            case (m_st)
                0: if (stop_req) begin
                       m_keep = cfg_pll_in_stop; m_skip = cfg_no_delay;
                       m_pllen = cfg_pll_en; m_st = 1;
                   end
                1: if (wake_irq) begin m_st = 2; m_rec = 0; m_seen = 0; end
                2: begin
                       lock_now = m_seen || pll_locked;
                       ok_d = (m_keep || m_skip) || (m_rec + 1 >= N);
                       ok_l = !(m_pllen && !m_keep) || lock_now;
                       if (ok_d && ok_l) begin m_st = 3; m_wake = wake_irq; end
                       else begin m_rec++; m_seen = lock_now; end
                   end
                default: begin m_st = 0; m_wake = 0; end
            endcase
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(cur_req, "osc_pd", osc_pd, (m_st == 1 && !m_keep));
            check(cur_req, "pll_pd", pll_pd, (m_st == 1 && !m_keep));
            check(cur_req, "core_release", core_release, (m_st == 3));
            check(cur_req, "wake_serviced", wake_serviced, (m_st == 3 && m_wake));
        end
    end

    // enter Stop, disturb inputs, wake, and time the release
    task automatic scenario(input string req, input bit keep, input bit skip,
                            input bit pllen, input int lock_at, input bit pulse,
                            input int hold, input int exp_lat);
        int n;
        cur_req = req;
        stop_req = 1; cfg_pll_in_stop = keep; cfg_no_delay = skip; cfg_pll_en = pllen;
        @(negedge clk);
        stop_req = 0;
        check("R2", "osc_pd after entry", osc_pd, !keep);
        // R10: config changes and stop_req while asleep are ignored
        cfg_pll_in_stop = !keep; cfg_no_delay = !skip; cfg_pll_en = !pllen;
        stop_req = 1;
        @(negedge clk);
        stop_req = 0;
        @(negedge clk);
        check("R10", "still asleep", pll_pd, !keep);
        wake_irq = 1;
        n = 0;
        while (n < 5000) begin
            @(negedge clk);
            n++;
            if (core_release) break;
            if (n == 2) stop_req = 1; else stop_req = 0;
            wake_irq   = (n - 1 < hold);
            pll_locked = pulse ? (n - 1 == lock_at) : (n - 1 >= lock_at);
        end
        check(req, "release latency", n, exp_lat + 1);
        check("R9", "serviced flag", wake_serviced, (exp_lat - 1 < hold));
        stop_req = 0; wake_irq = 0; pll_locked = 0;
        @(negedge clk);
        check("R8", "pulse ended", core_release, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1", "reset osc_pd", osc_pd, 0);
        check("R1", "reset release", core_release, 0);
        // R10: wake while running does nothing
        cur_req = "R10";
        wake_irq = 1;
        repeat (4) @(negedge clk);
        check("R10", "no pd from wake", osc_pd, 0);
        check("R10", "no release from wake", core_release, 0);
        wake_irq = 0;
        @(negedge clk);
        scenario("R4", 0, 0, 0, 100000, 0, N + 5, N);      // delay only, R7 lock unused
        scenario("R5", 0, 1, 0, 100000, 0, 0, 1);          // no waits, wake dropped
        scenario("R6", 0, 0, 1, 40, 0, 100, 41);           // lock slower than delay
        scenario("R6", 0, 0, 1, 5, 0, 100, N);             // delay slower than lock
        scenario("R6", 0, 0, 1, 3, 1, 0, N);               // brief lock pulse remembered
        scenario("R3", 1, 0, 1, 100000, 0, 100, 1);        // PLL kept running
        scenario("R5", 0, 1, 1, 7, 0, 3, 8);               // lock only, wake gone
        scenario("R7", 0, 0, 0, 0, 0, N - 1, N);           // lock ignored, wake gone late
        // R1: reset mid-Stop
        stop_req = 1; cfg_pll_in_stop = 0;
        @(negedge clk);
        stop_req = 0; rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1", "reset clears Stop", osc_pd, 0);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule